// File: doc/BRIEF.md
# Hardwired 8-bit Harvard Processor Core

This block is a compact 8-bit processor core. It reads instructions through one memory port and data through a separate port. Every control signal comes from a fixed combinational decoder, and there is no microcode store. Each instruction is one 8-bit word. The core works on four 8-bit general registers and keeps a zero flag and a carry flag. The top nibble of each word picks one of sixteen operations, and the low nibble names a destination register and a source register.

Each instruction runs as a short sequence of steps of one clock each. The sequence is fetch, operand read and execute. Only a taken branch or jump adds a fourth step, which loads the program counter. A conditional branch whose test fails ends after the execute step and moves on to the next address. A boot controller holds the run-enable input low until instruction memory is filled. While that input is low the core keeps its program counter at zero and does not fetch. A halt instruction stops the core until the next reset.

Top module: `hw8_core`

## Requirements
- R1: An instruction word has the opcode in bits 7:4, the destination register rd in bits 3:2 and the source register rs in bits 1:0. The opcode values are 0 no-op, 1 move (rd<=rs), 2 add (rd<=rd+rs), 3 subtract (rd<=rd-rs), 4 AND, 5 OR, 6 XOR, 7 load (rd<=data[rs]), 8 store (data[rs]<=rd), 9 load-low-immediate, 10 load-high-immediate, 11 jump, 12 branch-if-zero, 13 branch-if-carry, 14 compare, 15 halt.
- R2: While reset is asserted and after it is released, the core does the following until run-enable rises: halted is 0, neither memory port is enabled, and the registers, flags and program counter are zero.
- R3: While run-enable is low, the core performs no instruction fetch, and the program counter (shown on the instruction address) reads 0 from the next clock edge on. Dropping run-enable in the middle of an instruction abandons that instruction.
- R4: Every instruction other than a taken branch or a jump takes exactly 3 clock steps, and the instruction is fetched only in the first step. Two consecutive cycles never both fetch.
- R5: Add and subtract write the destination register and set zero when the 8-bit result is 0. Add sets carry to the carry-out of the sum. Subtract sets carry when a borrow occurs, so rd < rs unsigned gives carry 1.
- R6: AND, OR and XOR write the destination register, set zero when the result is 0 and clear carry.
- R7: A load reads data memory at the address held in rs into rd. A store writes rd to data memory at the address held in rs. At most one of the data read and data write enables is high in any cycle. Moves, loads, stores and immediates leave the flags unchanged.
- R8: Load-low-immediate sets register 0 to {0000, bits 3:0 of the word}. Load-high-immediate replaces bits 7:4 of register 0 with bits 3:0 of the word and keeps its low nibble.
- R9: Branch-if-zero and branch-if-carry test only their one flag. When the flag is set, the program counter loads the value of rs and the instruction takes 4 steps. When the flag is clear, the program counter increments and the instruction takes 3 steps.
- R10: A jump always loads the program counter from rs and takes 4 steps.
- R11: Compare sets zero and carry exactly as subtract does but writes no register.
- R12: A halt raises the halted output. The output stays high with no further fetch and a frozen instruction address until reset, whatever run-enable does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; every step is one rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | High lets the core execute; low holds it at address 0 |
| imem_addr | output | 8 | Instruction memory address (program counter) |
| imem_rd_en | output | 1 | High in the fetch step |
| imem_data | input | 8 | Instruction word read combinationally at imem_addr |
| dmem_addr | output | 8 | Data memory address for load and store |
| dmem_wdata | output | 8 | Store data |
| dmem_wr_en | output | 1 | Store strobe, one cycle |
| dmem_rd_en | output | 1 | Load strobe; dmem_rdata sampled in the same cycle |
| dmem_rdata | input | 8 | Data memory read value |
| halted | output | 1 | High once a halt has executed, until reset |

## Verification
The flags cannot be seen at the ports, so the hardest part is showing which flag state each branch saw. Short programs set up known flag states with subtract, compare and XOR. Each branch target is placed so that a wrong decision lands on a halt or loops back and adds stores. The bench counts the cycles from run-enable to halt and compares the total with the sum of 3 and 4 step costs, which exposes a branch taken or not taken in error. Run-enable is also dropped in the middle of an instruction and raised again, and the bench checks that the whole program then runs again from address 0.

// File: rtl/hw8_pkg.sv
package hw8_pkg;

  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 4'h0, OP_MOV = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_AND = 4'h4, OP_OR  = 4'h5, OP_XOR = 4'h6, OP_LD  = 4'h7,
    OP_ST  = 4'h8, OP_LIL = 4'h9, OP_LIH = 4'hA, OP_JMP = 4'hB,
    OP_BZ  = 4'hC, OP_BC  = 4'hD, OP_CMP = 4'hE, OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } alu_op_e;

  typedef enum logic [2:0] {
    WS_ALU, WS_MEM, WS_MOV, WS_LIL, WS_LIH
  } wsrc_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_ALWAYS, BR_ZERO, BR_CARRY
  } br_e;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_BRANCH, S_HALT
  } step_e;

  typedef struct packed {
    logic    reg_we;
    logic    to_r0;
    wsrc_e   wsrc;
    logic    flag_we;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    br_e     br;
    logic    halt;
  } ctrl_t;

endpackage

// File: rtl/hw8_decode.sv
module hw8_decode
  import hw8_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output ctrl_t          ctl
);

  always_comb begin
    ctl = '{reg_we: 1'b0, to_r0: 1'b0, wsrc: WS_ALU, flag_we: 1'b0,
            alu_op: ALU_ADD, mem_rd: 1'b0, mem_wr: 1'b0, br: BR_NONE,
            halt: 1'b0};
    unique case (opcode_e'(opcode))
      OP_MOV: begin ctl.reg_we = 1'b1; ctl.wsrc = WS_MOV; end
      OP_ADD: begin ctl.reg_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_ADD; end
      OP_SUB: begin ctl.reg_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_SUB; end
      OP_AND: begin ctl.reg_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_AND; end
      OP_OR:  begin ctl.reg_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_OR;  end
      OP_XOR: begin ctl.reg_we = 1'b1; ctl.flag_we = 1'b1; ctl.alu_op = ALU_XOR; end
      OP_LD:  begin ctl.reg_we = 1'b1; ctl.wsrc = WS_MEM; ctl.mem_rd = 1'b1; end
      OP_ST:  ctl.mem_wr = 1'b1;
      OP_LIL: begin ctl.reg_we = 1'b1; ctl.to_r0 = 1'b1; ctl.wsrc = WS_LIL; end
      OP_LIH: begin ctl.reg_we = 1'b1; ctl.to_r0 = 1'b1; ctl.wsrc = WS_LIH; end
      OP_JMP: ctl.br = BR_ALWAYS;
      OP_BZ:  ctl.br = BR_ZERO;
      OP_BC:  ctl.br = BR_CARRY;
      OP_CMP: begin ctl.flag_we = 1'b1; ctl.alu_op = ALU_SUB; end
      OP_HLT: ctl.halt = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/hw8_alu.sv
module hw8_alu
  import hw8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          c,
  output logic          z
);

  logic [DW:0] wide;

  always_comb begin
    wide = '0;
    unique case (op)
      ALU_ADD: wide = {1'b0, a} + {1'b0, b};
      ALU_SUB: wide = {1'b0, a} - {1'b0, b};
      ALU_AND: wide = {1'b0, a & b};
      ALU_OR:  wide = {1'b0, a | b};
      ALU_XOR: wide = {1'b0, a ^ b};
      default: wide = '0;
    endcase
    y = wide[DW-1:0];
    c = wide[DW];
    z = (wide[DW-1:0] == '0);
  end

endmodule

// File: rtl/hw8_regfile.sv
module hw8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [RW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  output logic [DW-1:0] r0_data
);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        r_q <= '0;
      else if (we && waddr == RW'(g))    r_q <= wdata;
    end
    assign regs[g] = r_q;
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign r0_data = regs[0];

endmodule

// File: rtl/hw8_core.sv
module hw8_core
  import hw8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  output logic [DW-1:0] imem_addr,
  output logic          imem_rd_en,
  input  logic [DW-1:0] imem_data,
  output logic [DW-1:0] dmem_addr,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_wr_en,
  output logic          dmem_rd_en,
  input  logic [DW-1:0] dmem_rdata,
  output logic          halted
);

  localparam int RW  = $clog2(NREG);
  localparam int IMW = DW - OPW;

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  step_e         st_q, st_d;
  logic [DW-1:0] pc_q, pc_d, ir_q, ir_d, opa_q, opa_d, opb_q, opb_d;
  logic          fz_q, fz_d, fc_q, fc_d;

  ctrl_t         ctl;
  logic [RW-1:0] rd_f, rs_f;
  logic [IMW-1:0] imm;
  logic          rf_we;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, ra_data, rb_data, r0_data;
  logic [DW-1:0] alu_y;
  logic          alu_c, alu_z, taken, active;

  assign rd_f = ir_q[2*RW-1:RW];
  assign rs_f = ir_q[RW-1:0];
  assign imm  = ir_q[IMW-1:0];

  hw8_decode u_dec (.opcode(ir_q[DW-1:IMW]), .ctl(ctl));

  hw8_alu #(.DW(DW)) u_alu (
    .op(ctl.alu_op), .a(opa_q), .b(opb_q), .y(alu_y), .c(alu_c), .z(alu_z)
  );

  hw8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_sync_n), .we(rf_we), .waddr(rf_waddr),
    .wdata(rf_wdata), .ra_addr(rd_f), .ra_data(ra_data),
    .rb_addr(rs_f), .rb_data(rb_data), .r0_data(r0_data)
  );

  assign active     = run_en && (st_q != S_HALT);
  assign halted     = (st_q == S_HALT);
  assign imem_addr  = pc_q;
  assign imem_rd_en = active && (st_q == S_FETCH);
  assign dmem_addr  = opb_q;
  assign dmem_wdata = opa_q;
  assign dmem_wr_en = active && (st_q == S_EXEC) && ctl.mem_wr;
  assign dmem_rd_en = active && (st_q == S_EXEC) && ctl.mem_rd;

  always_comb begin
    unique case (ctl.br)
      BR_ALWAYS: taken = 1'b1;
      BR_ZERO:   taken = fz_q;
      BR_CARRY:  taken = fc_q;
      default:   taken = 1'b0;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d = st_q; pc_d = pc_q; ir_d = ir_q;
    opa_d = opa_q; opb_d = opb_q; fz_d = fz_q; fc_d = fc_q;
    rf_we = 1'b0; rf_waddr = ctl.to_r0 ? '0 : rd_f;
    unique case (ctl.wsrc)
      WS_MEM:  rf_wdata = dmem_rdata;
      WS_MOV:  rf_wdata = opb_q;
      WS_LIL:  rf_wdata = {{(DW-IMW){1'b0}}, imm};
      WS_LIH:  rf_wdata = {imm, r0_data[DW-IMW-1:0]};
      default: rf_wdata = alu_y;
    endcase
    if (st_q != S_HALT) begin
      if (!run_en) begin
        st_d = S_FETCH;
        pc_d = '0;
      end else begin
        unique case (st_q)
          S_FETCH: begin
            ir_d = imem_data;
            st_d = S_DECODE;
          end
          S_DECODE: begin
            opa_d = ra_data;
            opb_d = rb_data;
            st_d  = S_EXEC;
          end
          S_EXEC: begin
            if (ctl.halt) begin
              st_d = S_HALT;
            end else begin
              rf_we = ctl.reg_we;
              if (ctl.flag_we) begin
                fz_d = alu_z;
                fc_d = alu_c;
              end
              st_d = taken ? S_BRANCH : S_FETCH;
              pc_d = taken ? pc_q : pc_q + 1'b1;
            end
          end
          S_BRANCH: begin
            pc_d = opb_q;
            st_d = S_FETCH;
          end
          default: st_d = S_FETCH;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= S_FETCH; pc_q <= '0; ir_q <= '0;
      opa_q <= '0; opb_q <= '0; fz_q <= 1'b0; fc_q <= 1'b0;
    end else begin
      st_q <= st_d; pc_q <= pc_d; ir_q <= ir_d;
      opa_q <= opa_d; opb_q <= opb_d; fz_q <= fz_d; fc_q <= fc_d;
    end
  end

  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |=> halted && $stable(imem_addr));
  // R12
  halt_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    halted |-> !imem_rd_en);
  // R3
  idle_pc_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run_en && !halted) |=> (imem_addr == '0));
  // R4
  fetch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    imem_rd_en |=> !imem_rd_en);
  // R7
  dmem_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({dmem_wr_en, dmem_rd_en}));
  // R6
  logic_clears_c_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (active && st_q == S_EXEC && ctl.flag_we &&
     (ctl.alu_op inside {ALU_AND, ALU_OR, ALU_XOR})) |=> !fc_q);

endmodule

// File: tb/sim_hw8_core.sv
module sim_hw8_core;

  logic       clk = 1'b0;
  logic       rst_n, run_en;
  logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic       imem_rd_en, dmem_wr_en, dmem_rd_en, halted;

  logic [7:0] imem [256];
  logic [7:0] dmem [256];

  int total = 0;
  int bad   = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #10ns clk = ~clk;

  hw8_core u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .imem_addr(imem_addr), .imem_rd_en(imem_rd_en), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_wr_en(dmem_wr_en),
    .dmem_rd_en(dmem_rd_en), .dmem_rdata(dmem_rdata), .halted(halted)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_wr_en) dmem[dmem_addr] <= dmem_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_store(input logic [7:0] a, input logic [7:0] d, input string tag);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  // monitor: pops the scoreboard at each store
  always @(negedge clk) begin
    if (rst_n && dmem_wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected store", {dmem_addr, dmem_wdata}, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({dmem_addr, dmem_wdata} == e, t, {dmem_addr, dmem_wdata}, e);
      end
    end
  end

  task automatic boot(input logic [7:0] prog [$]);
    rst_n = 1'b0; run_en = 1'b0;
    for (int i = 0; i < 256; i++) begin imem[i] = 8'hF0; dmem[i] = 8'h00; end
    foreach (prog[i]) imem[i] = prog[i];
    dmem[0] = 8'h3C;
    repeat (2) @(negedge clk);
    // R2: state while held in reset
    chk(!halted && !imem_rd_en && !dmem_wr_en && !dmem_rd_en, "R2 reset outputs",
        {halted, imem_rd_en, dmem_wr_en, dmem_rd_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: idle with run low
    chk(!imem_rd_en && imem_addr == 8'h00 && !halted, "R3 idle after reset",
        {imem_rd_en, imem_addr}, 0);
  endtask

  task automatic run_to_halt(input int exp_steps, input string tag);
    int cnt = 0;
    run_en = 1'b1;
    while (!halted && cnt < 1000) begin
      @(posedge clk); cnt++; @(negedge clk);
    end
    chk(cnt == exp_steps, tag, cnt, exp_steps);
    chk(exp_q.size() == 0, "R7 stores missing", exp_q.size(), 0);
  endtask

  initial begin
    #(20ns * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] p1 [$] = '{8'h95, 8'hAA, 8'h14, 8'h93, 8'h18, 8'h97, 8'h1C,
                           8'h26, 8'h87, 8'h39, 8'h8B, 8'h65, 8'h87, 8'h48,
                           8'h5B, 8'h8B, 8'h75, 8'h87, 8'hF0};
    logic [7:0] p2 [$] = '{8'h9F, 8'h18, 8'h9A, 8'h1C, 8'h91, 8'h14, 8'h31,
                           8'hD3, 8'hC3, 8'hF0, 8'h87, 8'h31, 8'hC2, 8'hD2,
                           8'hF0, 8'h8B, 8'hF0};
    logic [7:0] p3 [$] = '{8'h93, 8'hB0, 8'hF0, 8'hE4, 8'h84, 8'h6A, 8'hD0, 8'hF0};
    logic [7:0] frozen;

    // program 1: immediates, ALU, load/store; aborted once then restarted
    boot(p1);
    run_en = 1'b1;
    repeat (10) @(negedge clk);
    run_en = 1'b0;
    chk(!imem_rd_en, "R3 no fetch when run low", imem_rd_en, 0);
    @(negedge clk);
    chk(imem_addr == 8'h00, "R3 pc back to zero", imem_addr, 0);
    repeat (3) @(negedge clk);
    chk(!imem_rd_en && imem_addr == 8'h00, "R3 held idle", {imem_rd_en, imem_addr}, 0);
    expect_store(8'h07, 8'hA8, "R5 R8 add A5+03");
    expect_store(8'h07, 8'h5B, "R5 sub 03-A8");
    expect_store(8'h07, 8'h00, "R6 xor self");
    expect_store(8'h07, 8'h07, "R6 and/or");
    expect_store(8'h07, 8'h3C, "R7 load data[0]");
    run_to_halt(57, "R4 three-step instructions");

    // R12: halt holds whatever run_en does
    frozen = imem_addr;
    for (int i = 0; i < 12; i++) begin
      run_en = i[1];
      @(negedge clk);
      if (!halted || imem_rd_en || imem_addr != frozen)
        chk(1'b0, "R12 halt frozen", {halted, imem_rd_en, imem_addr}, {2'b10, frozen});
    end
    chk(halted && imem_addr == 8'h12, "R12 halt address", imem_addr, 8'h12);

    // program 2: branch taken / not taken on both flags
    boot(p2);
    expect_store(8'h0A, 8'h01, "R9 taken BZ target");
    expect_store(8'h0A, 8'h0F, "R9 taken BC target");
    run_to_halt(47, "R9 branch step costs");
    chk(imem_addr == 8'h10, "R9 final address", imem_addr, 8'h10);

    // program 3: jump, compare, logic clears carry
    boot(p3);
    expect_store(8'h03, 8'h00, "R11 compare writes nothing");
    run_to_halt(22, "R10 R6 jump cost and carry clear");
    chk(imem_addr == 8'h07, "R1 R10 final address", imem_addr, 8'h07);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule